// File: doc/BRIEF.md
# Scoped Write-Through L1 Data Cache Controller

This block is the private first-level data cache of one compute unit in a system where coherence is kept by the reader rather than by ownership. Each line carries nothing but a valid bit, plus one bit per word that marks words written into a line that has not been filled. Stores are written through, but they first wait in a small coalescing buffer. Two events drain that buffer to the shared second level: a globally scoped release, or the buffer becoming full. A globally scoped acquire is performed at the shared level and then flash-clears every line, so that no later load can hit data another unit has since replaced.

Synchronization requests carry a scope bit. Global-scope acquires and releases bypass the L1 and travel to the shared level. Local-scope ones are handled entirely inside the L1: a local acquire is served like a load with no invalidate, and a local release is buffered like a store with no drain. The compute-unit port uses a valid/ready handshake and accepts one request at a time, so requests complete in program order. Every accepted request produces exactly one response pulse. The memory port issues one transaction at a time and waits for its single response.

Top module: `scoped_wt_l1`

## Requirements
- R1: After reset, req_ready_o is high, and rsp_valid_o and mem_req_valid_o are low.
- R2: req_op_i encodes load 0, store 1, acquire 2, release 3, and req_global_i high selects global scope. A load that hits raises rsp_valid_o one cycle after acceptance and makes no memory request. A load that misses issues one read (mem_req_we_o low) at the line-aligned address and returns the requested word. mem_rsp_rdata_i carries the four-word line holding the address, with word k in bits [32k+31:32k].
- R3: A store responds one cycle after acceptance and causes no memory write by itself. Stores to an address that is already pending merge, so only the last value reaches memory, in a single write.
- R4: A load of an address with a pending buffered store returns the buffered value with no memory request, even when its line has been evicted from the L1.
- R5: A store to a non-resident line allocates that line holding only the stored word (lines are four words). A later fill of the line brings the other words from memory and keeps the stored word, even when memory holds a different value for it.
- R6: Once the buffer holds 8 distinct pending addresses, req_ready_o is low until all 8 have been written to memory and acknowledged.
- R7: A global acquire reads its word from memory, or from the buffer when a store to it is pending, and invalidates every line. A previously resident line then misses.
- R8: A local acquire neither invalidates nor accesses memory. It is served from the L1 in one cycle on a hit, even when memory has changed.
- R9: A global release writes all pending buffered stores to memory before its own write. It responds only after its own write is acknowledged.
- R10: A local release responds in one cycle with no memory traffic. Its value is seen by later loads and reaches memory at the next global release.
- R11: Requests offered while req_ready_o is low are held, not lost. Each accepted request produces exactly one response, in acceptance order.
- R12: While mem_req_valid_o is high and mem_req_ready_i is low, the memory request stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request offered by the compute unit |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_op_i | input | 2 | Operation: load, store, acquire, release |
| req_global_i | input | 1 | Scope: 1 global, 0 local |
| req_addr_i | input | 12 | Word address |
| req_wdata_i | input | 32 | Store or release data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Load or acquire data |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_we_o | output | 1 | 1 write, 0 read |
| mem_req_addr_o | output | 12 | Memory word address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_rsp_valid_i | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata_i | input | 128 | Line holding the requested address |

## Verification
Hits, stores and local synchronization must raise the response pulse exactly one cycle after the accepting edge. The bench counts the falling edges after acceptance and checks for a latency of one. Misses and global operations depend on the memory responder's randomized ready, so the bench waits for the response pulse, then compares the returned data and the memory model's read and write counts. The ready flag sampled one half-cycle after the buffer fills shows the back-pressure. Write order and contents are read back from the bench's memory model after each global release.

// File: rtl/scoped_l1_pkg.sv
package scoped_l1_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_ACQ   = 2'd2,
    OP_REL   = 2'd3
  } l1_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL_REQ,
    ST_FILL_WAIT,
    ST_DRAIN_REQ,
    ST_DRAIN_WAIT,
    ST_SYNC_REQ,
    ST_SYNC_WAIT
  } l1_state_e;

endpackage

// File: rtl/l1_line_store.sv
module l1_line_store #(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [AW-1:0]              rd_addr_i,
  output logic                       hit_o,
  output logic [DW-1:0]              rd_data_o,
  input  logic                       wr_en_i,
  input  logic                       wr_alloc_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  input  logic                       fill_en_i,
  input  logic [AW-1:0]              fill_addr_i,
  input  logic [LINE_WORDS*DW-1:0]   fill_data_i,
  input  logic                       flash_i
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = AW - OFF_W - IDX_W;

  logic [NUM_LINES-1:0]  line_v_q;
  logic [NUM_LINES-1:0]  filled_q;
  logic [LINE_WORDS-1:0] wmask_q [NUM_LINES];
  logic [TAG_W-1:0]      tag_q   [NUM_LINES];
  logic [DW-1:0]         data_q  [NUM_LINES][LINE_WORDS];

  logic [IDX_W-1:0] r_idx, w_idx, f_idx;
  logic [OFF_W-1:0] r_off, w_off;
  logic [TAG_W-1:0] r_tag, w_tag, f_tag;
  logic             r_same, w_same, f_same;
  logic [LINE_WORDS-1:0] w_onehot;

  assign r_off = rd_addr_i[OFF_W-1:0];
  assign r_idx = rd_addr_i[OFF_W +: IDX_W];
  assign r_tag = rd_addr_i[AW-1 -: TAG_W];
  assign w_off = wr_addr_i[OFF_W-1:0];
  assign w_idx = wr_addr_i[OFF_W +: IDX_W];
  assign w_tag = wr_addr_i[AW-1 -: TAG_W];
  assign f_idx = fill_addr_i[OFF_W +: IDX_W];
  assign f_tag = fill_addr_i[AW-1 -: TAG_W];

  assign r_same = line_v_q[r_idx] && (tag_q[r_idx] == r_tag);
  assign w_same = line_v_q[w_idx] && (tag_q[w_idx] == w_tag);
  assign f_same = line_v_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign w_onehot = LINE_WORDS'(1) << w_off;

  assign hit_o     = r_same && (filled_q[r_idx] || wmask_q[r_idx][r_off]);
  assign rd_data_o = data_q[r_idx][r_off];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_v_q <= '0;
      filled_q <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        wmask_q[i] <= '0;
        tag_q[i]   <= '0;
      end
    end else if (flash_i) begin
      line_v_q <= '0;
    end else if (fill_en_i) begin
      line_v_q[f_idx] <= 1'b1;
      filled_q[f_idx] <= 1'b1;
      tag_q[f_idx]    <= f_tag;
      if (!f_same) wmask_q[f_idx] <= '0;
    end else if (wr_en_i) begin
      if (w_same) begin
        wmask_q[w_idx][w_off] <= 1'b1;
      end else if (wr_alloc_i) begin
        line_v_q[w_idx] <= 1'b1;
        filled_q[w_idx] <= 1'b0;
        tag_q[w_idx]    <= w_tag;
        wmask_q[w_idx]  <= w_onehot;
      end
    end
  end

  // written words of a partial line survive the fill
  always_ff @(posedge clk_i) begin
    if (!flash_i && fill_en_i) begin
      for (int k = 0; k < LINE_WORDS; k++) begin
        if (!(f_same && wmask_q[f_idx][k])) data_q[f_idx][k] <= fill_data_i[k*DW +: DW];
      end
    end else if (!flash_i && wr_en_i && (w_same || wr_alloc_i)) begin
      data_q[w_idx][w_off] <= wr_data_i;
    end
  end

  p_flash_no_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_i |=> !hit_o);
  p_alloc_hits_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_alloc_i && !flash_i && !fill_en_i) |=> (line_v_q[$past(w_idx)] && wmask_q[$past(w_idx)][$past(w_off)]));

endmodule

// File: rtl/l1_wr_coalesce.sv
module l1_wr_coalesce #(
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_en_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  input  logic [AW-1:0] fwd_addr_i,
  output logic          fwd_hit_o,
  output logic [DW-1:0] fwd_data_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o,
  input  logic          pop_i,
  output logic          full_o,
  output logic          empty_o,
  output logic          last_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] v_q;
  logic [AW-1:0]    a_q [DEPTH];
  logic [DW-1:0]    d_q [DEPTH];
  logic [DEPTH-1:0] st_m, fw_m;
  logic [IW-1:0]    head_idx, free_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign st_m[g] = v_q[g] && (a_q[g] == st_addr_i);
    assign fw_m[g] = v_q[g] && (a_q[g] == fwd_addr_i);
  end

  always_comb begin
    logic hf, ff;
    fwd_data_o = '0;
    head_idx   = '0;
    free_idx   = '0;
    hf = 1'b0;
    ff = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (fw_m[i]) fwd_data_o = d_q[i];
      if (v_q[i] && !hf) begin
        head_idx = IW'(i);
        hf = 1'b1;
      end
      if (!v_q[i] && !ff) begin
        free_idx = IW'(i);
        ff = 1'b1;
      end
    end
  end

  assign fwd_hit_o   = |fw_m;
  assign head_addr_o = a_q[head_idx];
  assign head_data_o = d_q[head_idx];
  assign full_o      = &v_q;
  assign empty_o     = ~|v_q;
  assign last_o      = ($countones(v_q) == 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        a_q[i] <= '0;
        d_q[i] <= '0;
      end
    end else begin
      if (st_en_i) begin
        if (|st_m) begin
          for (int i = 0; i < DEPTH; i++) if (st_m[i]) d_q[i] <= st_data_i;
        end else begin
          v_q[free_idx] <= 1'b1;
          a_q[free_idx] <= st_addr_i;
          d_q[free_idx] <= st_data_i;
        end
      end
      if (pop_i) v_q[head_idx] <= 1'b0;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_i |-> !full_o);
  p_unique_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(st_m));
  p_pop_nonempty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/scoped_wt_l1.sv
module scoped_wt_l1 import scoped_l1_pkg::*; #(
  parameter int AW         = 12,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8,
  parameter int WB_DEPTH   = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [1:0]               req_op_i,
  input  logic                     req_global_i,
  input  logic [AW-1:0]            req_addr_i,
  input  logic [DW-1:0]            req_wdata_i,
  output logic                     rsp_valid_o,
  output logic [DW-1:0]            rsp_rdata_o,
  output logic                     mem_req_valid_o,
  input  logic                     mem_req_ready_i,
  output logic                     mem_req_we_o,
  output logic [AW-1:0]            mem_req_addr_o,
  output logic [DW-1:0]            mem_req_wdata_o,
  input  logic                     mem_rsp_valid_i,
  input  logic [LINE_WORDS*DW-1:0] mem_rsp_rdata_i
);
  localparam int OFF_W = $clog2(LINE_WORDS);

  l1_state_e state_q, state_d;
  l1_op_e    op_in, lat_op_q;
  logic [AW-1:0] lat_addr_q, look_addr;
  logic [DW-1:0] lat_wdata_q;
  logic drain_rel_q, drain_rel_d;
  logic rsp_valid_q, rsp_set;
  logic [DW-1:0] rsp_data_q, rsp_data_d;
  logic accept;

  logic arr_hit, arr_wr_en, arr_wr_alloc, arr_fill_en, arr_flash;
  logic [DW-1:0] arr_rdata, arr_wr_data;
  logic [AW-1:0] arr_wr_addr;

  logic wb_st_en, wb_pop, wb_full, wb_empty, wb_last, fwd_hit;
  logic [DW-1:0] fwd_data, head_data, mem_word;
  logic [AW-1:0] head_addr;

  assign op_in       = l1_op_e'(req_op_i);
  assign req_ready_o = (state_q == ST_IDLE) && !wb_full;
  assign accept      = req_valid_i && req_ready_o;
  assign look_addr   = (state_q == ST_IDLE) ? req_addr_i : lat_addr_q;
  assign mem_word    = mem_rsp_rdata_i[lat_addr_q[OFF_W-1:0]*DW +: DW];

  l1_line_store #(
    .AW(AW), .DW(DW), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) u_lines (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_addr_i  (look_addr),
    .hit_o      (arr_hit),
    .rd_data_o  (arr_rdata),
    .wr_en_i    (arr_wr_en),
    .wr_alloc_i (arr_wr_alloc),
    .wr_addr_i  (arr_wr_addr),
    .wr_data_i  (arr_wr_data),
    .fill_en_i  (arr_fill_en),
    .fill_addr_i(lat_addr_q),
    .fill_data_i(mem_rsp_rdata_i),
    .flash_i    (arr_flash)
  );

  l1_wr_coalesce #(
    .AW(AW), .DW(DW), .DEPTH(WB_DEPTH)
  ) u_wbuf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_en_i    (wb_st_en),
    .st_addr_i  (req_addr_i),
    .st_data_i  (req_wdata_i),
    .fwd_addr_i (look_addr),
    .fwd_hit_o  (fwd_hit),
    .fwd_data_o (fwd_data),
    .head_addr_o(head_addr),
    .head_data_o(head_data),
    .pop_i      (wb_pop),
    .full_o     (wb_full),
    .empty_o    (wb_empty),
    .last_o     (wb_last)
  );

  always_comb begin
    state_d         = state_q;
    drain_rel_d     = drain_rel_q;
    rsp_set         = 1'b0;
    rsp_data_d      = rsp_data_q;
    wb_st_en        = 1'b0;
    wb_pop          = 1'b0;
    arr_wr_en       = 1'b0;
    arr_wr_alloc    = 1'b0;
    arr_wr_addr     = req_addr_i;
    arr_wr_data     = req_wdata_i;
    arr_fill_en     = 1'b0;
    arr_flash       = 1'b0;
    mem_req_valid_o = 1'b0;
    mem_req_we_o    = 1'b0;
    mem_req_addr_o  = lat_addr_q;
    mem_req_wdata_o = lat_wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (op_in)
            OP_LOAD, OP_ACQ: begin
              if (op_in == OP_ACQ && req_global_i) begin
                state_d = ST_SYNC_REQ;
              end else if (fwd_hit) begin
                rsp_set    = 1'b1;
                rsp_data_d = fwd_data;
              end else if (arr_hit) begin
                rsp_set    = 1'b1;
                rsp_data_d = arr_rdata;
              end else begin
                state_d = ST_FILL_REQ;
              end
            end
            OP_STORE, OP_REL: begin
              if (op_in == OP_REL && req_global_i) begin
                if (wb_empty) begin
                  state_d = ST_SYNC_REQ;
                end else begin
                  state_d     = ST_DRAIN_REQ;
                  drain_rel_d = 1'b1;
                end
              end else begin
                wb_st_en     = 1'b1;
                arr_wr_en    = 1'b1;
                arr_wr_alloc = 1'b1;
                rsp_set      = 1'b1;
              end
            end
            default: ;
          endcase
        end else if (wb_full) begin
          state_d = ST_DRAIN_REQ;
        end
      end
      ST_DRAIN_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = head_addr;
        mem_req_wdata_o = head_data;
        if (mem_req_ready_i) state_d = ST_DRAIN_WAIT;
      end
      ST_DRAIN_WAIT: begin
        if (mem_rsp_valid_i) begin
          wb_pop      = 1'b1;
          arr_wr_en   = 1'b1;
          arr_wr_addr = head_addr;
          arr_wr_data = head_data;
          if (!wb_last) begin
            state_d = ST_DRAIN_REQ;
          end else if (drain_rel_q) begin
            state_d     = ST_SYNC_REQ;
            drain_rel_d = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_SYNC_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = (lat_op_q == OP_REL);
        if (mem_req_ready_i) state_d = ST_SYNC_WAIT;
      end
      ST_SYNC_WAIT: begin
        if (mem_rsp_valid_i) begin
          rsp_set = 1'b1;
          state_d = ST_IDLE;
          if (lat_op_q == OP_REL) begin
            arr_wr_en   = 1'b1;
            arr_wr_addr = lat_addr_q;
            arr_wr_data = lat_wdata_q;
          end else begin
            arr_flash  = 1'b1;
            rsp_data_d = fwd_hit ? fwd_data : mem_word;
          end
        end
      end
      ST_FILL_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = {lat_addr_q[AW-1:OFF_W], {OFF_W{1'b0}}};
        if (mem_req_ready_i) state_d = ST_FILL_WAIT;
      end
      ST_FILL_WAIT: begin
        if (mem_rsp_valid_i) begin
          arr_fill_en = 1'b1;
          rsp_set     = 1'b1;
          rsp_data_d  = mem_word;
          state_d     = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lat_op_q    <= OP_LOAD;
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
      drain_rel_q <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      drain_rel_q <= drain_rel_d;
      rsp_valid_q <= rsp_set;
      rsp_data_q  <= rsp_data_d;
      if (accept) begin
        lat_op_q    <= op_in;
        lat_addr_q  <= req_addr_i;
        lat_wdata_q <= req_wdata_i;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  // outstanding-request tracker for the ordering checks
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= accept || (pend_q && !rsp_valid_o);
  end

  p_rsp_needs_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> pend_q);
  p_one_in_flight_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (!pend_q || rsp_valid_o));
  p_mem_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_we_o) && $stable(mem_req_wdata_o)));
  p_rel_after_drain_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && state_q == ST_SYNC_REQ && lat_op_q == OP_REL) |-> wb_empty);
  p_stall_when_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_full |-> !req_ready_o);

endmodule

// File: tb/scoped_wt_l1_tb_top.sv
`timescale 1ns/1ps
module scoped_wt_l1_tb_top;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, AQ = 2'd2, RL = 2'd3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic req_valid_i = 1'b0, req_ready_o, req_global_i = 1'b0;
  logic [1:0] req_op_i = '0;
  logic [11:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic rsp_valid_o;
  logic [31:0] rsp_rdata_o;
  logic mem_req_valid_o, mem_req_ready_i, mem_req_we_o;
  logic [11:0] mem_req_addr_o;
  logic [31:0] mem_req_wdata_o;
  logic mem_rsp_valid_i;
  logic [127:0] mem_rsp_rdata_i;

  scoped_wt_l1 dut_i (.*);

  // shared-level model with one-cycle response and random stalls
  logic [31:0] l2 [4096];
  int rd_cnt, wr_cnt;
  logic [11:0] last_wr_addr;
  logic ext_en = 1'b0;
  logic [11:0] ext_a = '0;
  logic [31:0] ext_d = '0;

  function automatic logic [31:0] init_val(int i);
    return 32'hC0DE_0000 ^ (i * 32'h0001_0101);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4096; i++) l2[i] <= init_val(i);
      rd_cnt <= 0; wr_cnt <= 0; last_wr_addr <= '0;
      mem_rsp_valid_i <= 1'b0; mem_rsp_rdata_i <= '0; mem_req_ready_i <= 1'b0;
    end else begin
      mem_req_ready_i <= ($urandom % 4) != 0;
      mem_rsp_valid_i <= mem_req_valid_o && mem_req_ready_i;
      if (ext_en) l2[ext_a] <= ext_d;
      if (mem_req_valid_o && mem_req_ready_i) begin
        if (mem_req_we_o) begin
          l2[mem_req_addr_o] <= mem_req_wdata_o;
          wr_cnt <= wr_cnt + 1;
          last_wr_addr <= mem_req_addr_o;
        end else begin
          rd_cnt <= rd_cnt + 1;
        end
        for (int k = 0; k < 4; k++)
          mem_rsp_rdata_i[k*32 +: 32] <= l2[{mem_req_addr_o[11:2], 2'(k)}];
      end
    end
  end

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ext_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i); ext_en = 1'b1; ext_a = a; ext_d = d;
    @(negedge clk_i); ext_en = 1'b0;
  endtask

  logic [31:0] r_data;
  int r_lat;
  logic r_rdy;

  task automatic do_req(input logic [1:0] op, input logic g, input logic [11:0] a, input logic [31:0] wd);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = op; req_global_i = g; req_addr_i = a; req_wdata_i = wd;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    r_lat = 1;
    r_rdy = req_ready_o;
    while (!rsp_valid_o && r_lat < 2000) begin
      @(negedge clk_i);
      r_lat++;
    end
    r_data = rsp_rdata_o;
    if (!rsp_valid_o) chk(1'b0, "R11 response missing", 32'(r_lat), 32'd0);
  endtask

  logic [31:0] shadow [64];

  initial begin
    int rc, wc;
    logic [31:0] v0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1 ready after reset", 32'(req_ready_o), 32'd1);
    chk(rsp_valid_o == 1'b0, "R1 rsp idle after reset", 32'(rsp_valid_o), 32'd0);
    chk(mem_req_valid_o == 1'b0, "R1 mem idle after reset", 32'(mem_req_valid_o), 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 miss then hit
    rc = rd_cnt;
    do_req(LD, 1'b0, 12'h010, '0);
    chk(r_data == init_val('h010), "R2 miss data", r_data, init_val('h010));
    chk(rd_cnt == rc + 1, "R2 miss one read", 32'(rd_cnt), 32'(rc + 1));
    do_req(LD, 1'b0, 12'h011, '0);
    chk(r_data == init_val('h011) && r_lat == 1, "R2 hit data/latency", r_data, init_val('h011));
    chk(rd_cnt == rc + 1, "R2 hit no read", 32'(rd_cnt), 32'(rc + 1));

    // R3 coalescing, R9 release ordering
    wc = wr_cnt;
    do_req(ST, 1'b0, 12'h020, 32'h1111_0001);
    chk(r_lat == 1, "R3 store latency", 32'(r_lat), 32'd1);
    do_req(ST, 1'b0, 12'h020, 32'h1111_0002);
    chk(wr_cnt == wc, "R3 no write before release", 32'(wr_cnt), 32'(wc));
    do_req(RL, 1'b1, 12'h3F0, 32'h5EED_0001);
    chk(l2['h020] == 32'h1111_0002, "R3 last value written", l2['h020], 32'h1111_0002);
    chk(wr_cnt == wc + 2, "R3 single merged write", 32'(wr_cnt), 32'(wc + 2));
    chk(last_wr_addr == 12'h3F0 && l2['h3F0] == 32'h5EED_0001, "R9 release write last",
        32'(last_wr_addr), 32'h3F0);

    // R4 forwarding after eviction
    rc = rd_cnt;
    do_req(ST, 1'b0, 12'h040, 32'hAAAA_0040);
    do_req(ST, 1'b0, 12'h060, 32'hBBBB_0060);
    do_req(LD, 1'b0, 12'h040, '0);
    chk(r_data == 32'hAAAA_0040 && r_lat == 1, "R4 forwarded value", r_data, 32'hAAAA_0040);
    chk(rd_cnt == rc, "R4 no read", 32'(rd_cnt), 32'(rc));

    // R5 partial line merge
    do_req(ST, 1'b0, 12'h101, 32'h7777_0101);
    do_req(RL, 1'b1, 12'h3F1, 32'h5EED_0002);
    ext_write(12'h101, 32'hDEAD_0101);
    rc = rd_cnt;
    do_req(LD, 1'b0, 12'h102, '0);
    chk(r_data == init_val('h102) && rd_cnt == rc + 1, "R5 other word fills", r_data, init_val('h102));
    do_req(LD, 1'b0, 12'h101, '0);
    chk(r_data == 32'h7777_0101 && r_lat == 1, "R5 written word kept", r_data, 32'h7777_0101);

    // R8 local acquire keeps stale copy, R7 global acquire invalidates
    do_req(LD, 1'b0, 12'h200, '0);
    v0 = r_data;
    ext_write(12'h200, 32'h0BAD_0200);
    rc = rd_cnt; wc = wr_cnt;
    do_req(AQ, 1'b0, 12'h200, '0);
    chk(r_data == v0 && r_lat == 1, "R8 local acquire stale hit", r_data, v0);
    chk(rd_cnt == rc && wr_cnt == wc, "R8 no traffic", 32'(rd_cnt), 32'(rc));
    do_req(AQ, 1'b1, 12'h300, '0);
    chk(r_data == init_val('h300) && rd_cnt == rc + 1, "R7 acquire at memory", r_data, init_val('h300));
    do_req(LD, 1'b0, 12'h200, '0);
    chk(r_data == 32'h0BAD_0200 && rd_cnt == rc + 2, "R7 line invalidated", r_data, 32'h0BAD_0200);
    do_req(ST, 1'b0, 12'h301, 32'h3030_0301);
    do_req(AQ, 1'b1, 12'h301, '0);
    chk(r_data == 32'h3030_0301, "R7 acquire sees pending store", r_data, 32'h3030_0301);

    // R10 local release
    wc = wr_cnt;
    do_req(RL, 1'b0, 12'h220, 32'h2200_0220);
    chk(r_lat == 1 && wr_cnt == wc, "R10 local release no drain", 32'(wr_cnt), 32'(wc));
    do_req(LD, 1'b0, 12'h220, '0);
    chk(r_data == 32'h2200_0220, "R10 value visible", r_data, 32'h2200_0220);
    do_req(RL, 1'b1, 12'h3F2, 32'h5EED_0003);
    chk(l2['h220] == 32'h2200_0220, "R10 reaches memory", l2['h220], 32'h2200_0220);

    // R6 full buffer, R11 back-pressured request
    wc = wr_cnt;
    for (int i = 0; i < 8; i++) begin
      do_req(ST, 1'b0, 12'h400 + 12'(i), 32'h4400_0000 + 32'(i));
      if (i < 7) chk(r_rdy == 1'b1, "R6 ready while not full", 32'(r_rdy), 32'd1);
    end
    chk(r_rdy == 1'b0, "R6 stall when full", 32'(r_rdy), 32'd0);
    do_req(LD, 1'b0, 12'h403, '0);
    chk(wr_cnt == wc + 8, "R6 full drain", 32'(wr_cnt), 32'(wc + 8));
    chk(r_data == 32'h4400_0003, "R11 held request served", r_data, 32'h4400_0003);
    chk(l2['h407] == 32'h4400_0007, "R6 drained data", l2['h407], 32'h4400_0007);

    // random phase on a conflicting window, R2 R3 R4 R7 R10 R11
    do_req(AQ, 1'b1, 12'h3F3, '0);
    for (int i = 0; i < 64; i++) shadow[i] = l2[12'h800 + 12'(i)];
    for (int n = 0; n < 400; n++) begin
      int a, k;
      logic g;
      logic [31:0] d;
      a = $urandom % 64;
      k = $urandom % 6;
      g = (k >= 4);
      d = $urandom;
      case (k)
        0, 1: begin
          do_req(LD, 1'b0, 12'h800 + 12'(a), '0);
          chk(r_data == shadow[a], "R2 random load", r_data, shadow[a]);
        end
        2: begin do_req(ST, 1'b0, 12'h800 + 12'(a), d); shadow[a] = d; end
        3: begin do_req(RL, 1'b0, 12'h800 + 12'(a), d); shadow[a] = d; end
        4: begin
          do_req(AQ, g, 12'h800 + 12'(a), '0);
          chk(r_data == shadow[a], "R7 random global acquire", r_data, shadow[a]);
        end
        default: begin do_req(RL, g, 12'h800 + 12'(a), d); shadow[a] = d; end
      endcase
    end
    do_req(RL, 1'b1, 12'h3F4, 32'h5EED_0004);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 64; i++) if (l2[12'h800 + 12'(i)] != shadow[i]) bad++;
      chk(bad == 0, "R9 memory matches after release", 32'(bad), 32'd0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule